// File: doc/BRIEF.md
# Masked One-Shot Alarm Interrupt Unit

This unit watches a live calendar (second, minute, hour, day of month, day of week, month, year) and raises an interrupt when the calendar reaches a programmed alarm time. The calendar counters sit outside the unit and feed it as inputs, together with a one-cycle seconds tick that is asserted after the calendar has advanced. A mask register drops chosen fields from the comparison, so the same hardware can serve a daily, hourly or weekday-independent alarm.

Software writes the seven alarm words into a staging copy through a small word-wide register port. The staged words have no effect until a shared commit strobe copies all seven at once into the live copy that the comparator uses. A comparison therefore never sees a mix of old and new alarm fields. On a match, with the alarm enabled, an alarm status bit is set and a level-high interrupt is driven. In one-shot mode the unit clears its own alarm enable as it fires. A second status bit records a low-power event from outside, with its own interrupt enable. Reading the status register clears it.

Top module: `alarm_unit`

## Requirements
- R1: After reset every register reads zero, the interrupt output is low and the read data output is zero.
- R2: A write to an alarm word (byte offsets 0x18, 0x1A, 0x1C, 0x1E, 0x20, 0x22, 0x24 for second, minute, hour, day of month, day of week, month, year) updates the staged copy, whose full 16 bits read back at once, but the comparison keeps using the live copy until a commit.
- R3: A pulse on commit_i copies all seven staged words into the live copy in one cycle.
- R4: On a cycle with tick_i high, a match occurs when every unmasked field equals its calendar input over the field's low bits (widths 6, 6, 5, 5, 3, 4, 7 in the R2 order). Upper bits of the alarm words are ignored. A match with the alarm enable (bit 0 of the enable register at 0x04) set sets alarm status bit 0 of the status register at 0x02.
- R5: Bit i of the mask register at 0x08 excludes field i (R2 order) from the match. Bit 4 excludes the day of week.
- R6: With the alarm enable clear, or without tick_i, the alarm status bit is not set.
- R7: With the one-shot bit (bit 2 of the enable register) set, the alarm enable clears in the same cycle the alarm status sets, and the one-shot bit stays. Without one-shot the alarm enable stays set.
- R8: A read of the status register returns its value one cycle later on rdata_o and clears it. A status event in the same cycle as the read wins and leaves its bit set.
- R9: irq_o is high exactly while alarm status is set, or while low-power status (bit 3) is set together with the low-power interrupt enable (bit 3 of the enable register).
- R10: A pulse on lp_event_i sets low-power status bit 3 regardless of enables.
- R11: The enable register reads back only bits 0, 2 and 3. The mask register reads back only bits 6:0. All other bits read zero.
- R12: A read of any byte offset other than the status, enable, mask and alarm words returns zero, and a write to such an offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Seconds tick, calendar already updated |
| sec_i | input | 6 | Calendar seconds |
| min_i | input | 6 | Calendar minutes |
| hour_i | input | 5 | Calendar hours |
| dom_i | input | 5 | Calendar day of month |
| dow_i | input | 3 | Calendar day of week |
| mon_i | input | 4 | Calendar month |
| year_i | input | 7 | Calendar year offset |
| lp_event_i | input | 1 | Low-power event pulse |
| commit_i | input | 1 | Shared commit strobe for staged alarm words |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 6 | Register byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after rd_en_i |
| irq_o | output | 1 | Level-high interrupt |

## Verification
The properties assume the register port does not write the enable register in the cycle a one-shot alarm fires, since a write there takes precedence over the self-clear. They also assume that a raised interrupt always traces back to a tick, a low-power event or a register write in the cycle before. The stimulus keeps these conditions by never overlapping register writes with ticks or event pulses. Only the directed same-cycle test combines a status read with a matching tick, and that case is outside both assumptions.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NF = 7;
  localparam int DW = 16;
  localparam int AW = 6;

  localparam logic [AW-1:0] ADDR_STA  = 6'h02;
  localparam logic [AW-1:0] ADDR_EN   = 6'h04;
  localparam logic [AW-1:0] ADDR_MASK = 6'h08;
  localparam logic [AW-1:0] ADDR_AL0  = 6'h18;

  localparam int BIT_AL = 0;
  localparam int BIT_OS = 2;
  localparam int BIT_LP = 3;

  typedef logic [NF-1:0][DW-1:0] field_arr_t;

  function automatic int field_width(input int idx);
    case (idx)
      0, 1:    return 6;
      2, 3:    return 5;
      4:       return 3;
      5:       return 4;
      default: return 7;
    endcase
  endfunction

  function automatic logic [AW-1:0] field_addr(input int idx);
    return ADDR_AL0 + AW'(2 * idx);
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_pkg::*;
#(
  parameter int N_FIELD = NF,
  parameter int D_W     = DW,
  parameter int A_W     = AW
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [A_W-1:0]                 addr_i,
  input  logic [D_W-1:0]                 wdata_i,
  input  logic                           commit_i,
  output logic [N_FIELD-1:0][D_W-1:0]    shadow_o,
  output logic [N_FIELD-1:0][D_W-1:0]    active_o
);
  for (genvar g = 0; g < N_FIELD; g++) begin : g_field
    logic hit;
    assign hit = wr_en_i && (addr_i == field_addr(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_o[g] <= '0;
        active_o[g] <= '0;
      end else begin
        if (hit)      shadow_o[g] <= wdata_i;
        if (commit_i) active_o[g] <= shadow_o[g];
      end
    end
  end
endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import alarm_pkg::*;
#(
  parameter int N_FIELD = NF,
  parameter int D_W     = DW
) (
  input  logic [N_FIELD-1:0][D_W-1:0] active_i,
  input  logic [N_FIELD-1:0][D_W-1:0] cal_i,
  input  logic [N_FIELD-1:0]          mask_i,
  output logic                        match_o
);
  logic [N_FIELD-1:0] eq;

  for (genvar g = 0; g < N_FIELD; g++) begin : g_cmp
    localparam int FW = field_width(g);
    assign eq[g] = mask_i[g] || (active_i[g][FW-1:0] == cal_i[g][FW-1:0]);
  end

  assign match_o = &eq;
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_pkg::*;
#(
  parameter int N_FIELD = NF,
  parameter int D_W     = DW,
  parameter int A_W     = AW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [A_W-1:0]     addr_i,
  input  logic [D_W-1:0]     wdata_i,
  input  logic               tick_i,
  input  logic               match_i,
  input  logic               lp_event_i,
  output logic [N_FIELD-1:0] mask_o,
  output logic               en_al_o,
  output logic               en_os_o,
  output logic               en_lp_o,
  output logic               st_al_o,
  output logic               st_lp_o,
  output logic               irq_o
);
  logic wr_en, wr_mask, rd_sta, fire;

  assign wr_en   = wr_en_i && (addr_i == ADDR_EN);
  assign wr_mask = wr_en_i && (addr_i == ADDR_MASK);
  assign rd_sta  = rd_en_i && (addr_i == ADDR_STA);
  assign fire    = tick_i && match_i && en_al_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_al_o <= 1'b0;
      en_os_o <= 1'b0;
      en_lp_o <= 1'b0;
      mask_o  <= '0;
    end else begin
      if (wr_en) begin
        en_al_o <= wdata_i[BIT_AL];
        en_os_o <= wdata_i[BIT_OS];
        en_lp_o <= wdata_i[BIT_LP];
      end else if (fire && en_os_o) begin
        en_al_o <= 1'b0;
      end
      if (wr_mask) mask_o <= wdata_i[N_FIELD-1:0];
    end
  end

  // set beats read-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_al_o <= 1'b0;
      st_lp_o <= 1'b0;
    end else begin
      if (fire)        st_al_o <= 1'b1;
      else if (rd_sta) st_al_o <= 1'b0;
      if (lp_event_i)  st_lp_o <= 1'b1;
      else if (rd_sta) st_lp_o <= 1'b0;
    end
  end

  assign irq_o = st_al_o || (st_lp_o && en_lp_o);
endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
  import alarm_pkg::*;
#(
  parameter int N_FIELD = NF,
  parameter int D_W     = DW,
  parameter int A_W     = AW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic [5:0]     sec_i,
  input  logic [5:0]     min_i,
  input  logic [4:0]     hour_i,
  input  logic [4:0]     dom_i,
  input  logic [2:0]     dow_i,
  input  logic [3:0]     mon_i,
  input  logic [6:0]     year_i,
  input  logic           lp_event_i,
  input  logic           commit_i,
  input  logic           wr_en_i,
  input  logic           rd_en_i,
  input  logic [A_W-1:0] addr_i,
  input  logic [D_W-1:0] wdata_i,
  output logic [D_W-1:0] rdata_o
  ,
  output logic           irq_o
);
  logic [N_FIELD-1:0][D_W-1:0] shadow_w, active_w, cal_w;
  logic [N_FIELD-1:0]          mask_w;
  logic match_w, en_al_w, en_os_w, en_lp_w, st_al_w, st_lp_w;
  logic [D_W-1:0] rd_next;

  always_comb begin
    cal_w    = '0;
    cal_w[0] = D_W'(sec_i);
    cal_w[1] = D_W'(min_i);
    cal_w[2] = D_W'(hour_i);
    cal_w[3] = D_W'(dom_i);
    cal_w[4] = D_W'(dow_i);
    cal_w[5] = D_W'(mon_i);
    cal_w[6] = D_W'(year_i);
  end

  alarm_regs #(.N_FIELD(N_FIELD), .D_W(D_W), .A_W(A_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .commit_i (commit_i),
    .shadow_o (shadow_w),
    .active_o (active_w)
  );

  alarm_match #(.N_FIELD(N_FIELD), .D_W(D_W)) u_match (
    .active_i (active_w),
    .cal_i    (cal_w),
    .mask_i   (mask_w),
    .match_o  (match_w)
  );

  alarm_irq_ctrl #(.N_FIELD(N_FIELD), .D_W(D_W), .A_W(A_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .tick_i     (tick_i),
    .match_i    (match_w),
    .lp_event_i (lp_event_i),
    .mask_o     (mask_w),
    .en_al_o    (en_al_w),
    .en_os_o    (en_os_w),
    .en_lp_o    (en_lp_w),
    .st_al_o    (st_al_w),
    .st_lp_o    (st_lp_w),
    .irq_o      (irq_o)
  );

  always_comb begin
    rd_next = '0;
    if (addr_i == ADDR_STA) begin
      rd_next[BIT_AL] = st_al_w;
      rd_next[BIT_LP] = st_lp_w;
    end else if (addr_i == ADDR_EN) begin
      rd_next[BIT_AL] = en_al_w;
      rd_next[BIT_OS] = en_os_w;
      rd_next[BIT_LP] = en_lp_w;
    end else if (addr_i == ADDR_MASK) begin
      rd_next[N_FIELD-1:0] = mask_w;
    end else begin
      for (int i = 0; i < N_FIELD; i++)
        if (addr_i == field_addr(i)) rd_next = shadow_w[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_next;
  end
endmodule

// File: rtl/alarm_unit_chk.sv
module alarm_unit_chk
  import alarm_pkg::*;
#(
  parameter int N_FIELD = NF,
  parameter int D_W     = DW,
  parameter int A_W     = AW
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        tick_i,
  input logic                        lp_event_i,
  input logic                        commit_i,
  input logic                        wr_en_i,
  input logic                        rd_en_i,
  input logic [A_W-1:0]              addr_i,
  input logic                        irq_o,
  input logic                        match,
  input logic                        en_al,
  input logic                        en_os,
  input logic                        st_al,
  input logic [N_FIELD-1:0][D_W-1:0] shadow,
  input logic [N_FIELD-1:0][D_W-1:0] active
);
  // R3
  commit_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> active == $past(shadow));

  // R2
  active_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(active));

  // R4
  fire_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && match && en_al |=> st_al);

  // R7
  oneshot_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && match && en_al && en_os && !(wr_en_i && addr_i == ADDR_EN) |=> !en_al);

  // R8
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i == ADDR_STA && !tick_i && !lp_event_i |=> !irq_o);

  // R9
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(tick_i || lp_event_i || wr_en_i));
endmodule

bind alarm_unit alarm_unit_chk #(.N_FIELD(N_FIELD), .D_W(D_W), .A_W(A_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .lp_event_i (lp_event_i),
  .commit_i   (commit_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .irq_o      (irq_o),
  .match      (match_w),
  .en_al      (en_al_w),
  .en_os      (en_os_w),
  .st_al      (st_al_w),
  .shadow     (shadow_w),
  .active     (active_w)
);

// File: tb/sim_alarm_unit.sv
module sim_alarm_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 40;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        lp_event_i = 1'b0;
  logic        commit_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        irq_o;
  logic [15:0] cal [7];

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  alarm_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
    .sec_i(cal[0][5:0]), .min_i(cal[1][5:0]), .hour_i(cal[2][4:0]),
    .dom_i(cal[3][4:0]), .dow_i(cal[4][2:0]), .mon_i(cal[5][3:0]),
    .year_i(cal[6][6:0]), .lp_event_i(lp_event_i), .commit_i(commit_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [15:0] fmask(input int i);
    int w;
    w = (i < 2) ? 6 : (i < 4) ? 5 : (i == 4) ? 3 : (i == 5) ? 4 : 7;
    return 16'((1 << w) - 1);
  endfunction

  function automatic bit exp_match(input logic [15:0] al [7], input logic [15:0] tm [7],
                                   input logic [6:0] msk);
    for (int i = 0; i < 7; i++)
      if (!msk[i] && ((al[i] & fmask(i)) != (tm[i] & fmask(i)))) return 0;
    return 1;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk_i); wr_en_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); wr_en_i = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk_i); rd_en_i = 1; addr_i = a;
    @(negedge clk_i); rd_en_i = 0; d = rdata_o;
  endtask

  task automatic pulse_commit();
    @(negedge clk_i); commit_i = 1;
    @(negedge clk_i); commit_i = 0;
  endtask

  task automatic tick_at(input logic [15:0] tm [7]);
    @(negedge clk_i); for (int i = 0; i < 7; i++) cal[i] = tm[i] & fmask(i); tick_i = 1;
    @(negedge clk_i); tick_i = 0;
  endtask

  task automatic load_alarm(input logic [15:0] al [7]);
    for (int i = 0; i < 7; i++) wr(6'h18 + 6'(2 * i), al[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [15:0] al [7];
    logic [15:0] tm [7];
    logic [6:0]  msk;
    bit os, em;
    void'($urandom(32'd2024));
    for (int i = 0; i < 7; i++) cal[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // R1 reset state
    @(negedge clk_i);
    chk("R1 irq", 16'(irq_o), 16'h0);
    chk("R1 rdata", rdata_o, 16'h0);
    rd(6'h02, d); chk("R1 status", d, 16'h0);
    rd(6'h04, d); chk("R1 enable", d, 16'h0);
    rd(6'h08, d); chk("R1 mask", d, 16'h0);
    rd(6'h24, d); chk("R1 alarm year", d, 16'h0);

    // R12 unmapped offset
    wr(6'h06, 16'hffff);
    rd(6'h06, d); chk("R12 unmapped read", d, 16'h0);
    rd(6'h04, d); chk("R12 enable untouched", d, 16'h0);

    // R2 staged write does not reach compare
    wr(6'h18, 16'hc005);
    rd(6'h18, d); chk("R2 staged readback", d, 16'hc005);
    wr(6'h04, 16'h0001);
    for (int i = 0; i < 7; i++) tm[i] = '0;
    tick_at(tm); chk("R2 live still zero matches", 16'(irq_o), 16'h1);
    rd(6'h02, d); chk("R8 status read value", d, 16'h0001);
    chk("R8 irq cleared", 16'(irq_o), 16'h0);
    tm[0] = 16'd5;
    tick_at(tm); chk("R2 staged value unused", 16'(irq_o), 16'h0);
    // R3 commit, R4 upper bits ignored
    pulse_commit();
    tick_at(tm); chk("R3 committed alarm fires", 16'(irq_o), 16'h1);
    rd(6'h02, d);
    rd(6'h04, d); chk("R7 no one-shot keeps enable", d, 16'h0001);

    // R6 disabled and no tick
    wr(6'h04, 16'h0000);
    tick_at(tm); chk("R6 disabled no irq", 16'(irq_o), 16'h0);
    rd(6'h02, d); chk("R6 disabled no status", d, 16'h0);
    wr(6'h04, 16'h0001);
    for (int i = 0; i < 7; i++) cal[i] = tm[i];
    repeat (3) @(negedge clk_i);
    chk("R6 no tick no irq", 16'(irq_o), 16'h0);

    // R5 day-of-week mask
    al = '{16'd30, 16'd15, 16'd9, 16'd21, 16'd3, 16'd11, 16'd55};
    load_alarm(al); pulse_commit();
    tm = al; tm[4] = 16'd5;
    tick_at(tm); chk("R5 dow unmasked mismatch", 16'(irq_o), 16'h0);
    wr(6'h08, 16'hff10);
    rd(6'h08, d); chk("R11 mask readback", d, 16'h0010);
    tick_at(tm); chk("R5 dow masked match", 16'(irq_o), 16'h1);
    rd(6'h02, d);

    // R7 one-shot
    wr(6'h04, 16'hfff5 & ~16'h0008);
    tick_at(tm); chk("R7 one-shot fires", 16'(irq_o), 16'h1);
    rd(6'h04, d); chk("R7 enable cleared, one-shot kept", d, 16'h0004);
    rd(6'h02, d); chk("R7 status set", d, 16'h0001);
    tick_at(tm); chk("R7 no second fire", 16'(irq_o), 16'h0);

    // R8 set in the same cycle as read-clear
    wr(6'h04, 16'h0001);
    @(negedge clk_i); rd_en_i = 1; addr_i = 6'h02; tick_i = 1;
    for (int i = 0; i < 7; i++) cal[i] = tm[i];
    @(negedge clk_i); rd_en_i = 0; tick_i = 0;
    chk("R8 read before set", rdata_o, 16'h0);
    chk("R8 set wins", 16'(irq_o), 16'h1);
    rd(6'h02, d);

    // R10 / R9 low-power event
    wr(6'h04, 16'h0000);
    @(negedge clk_i); lp_event_i = 1;
    @(negedge clk_i); lp_event_i = 0;
    chk("R9 lp gated off", 16'(irq_o), 16'h0);
    wr(6'h04, 16'h0008);
    chk("R9 lp enabled irq", 16'(irq_o), 16'h1);
    rd(6'h02, d); chk("R10 lp status", d, 16'h0008);
    chk("R9 irq low after clear", 16'(irq_o), 16'h0);

    // Random vectors, R4/R5/R7/R9/R11
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < 7; i++) al[i] = 16'($urandom);
      msk = 7'($urandom) & ((($urandom % 3) == 0) ? 7'h7f : 7'h00);
      os = 1'($urandom);
      if ($urandom % 2) begin
        for (int i = 0; i < 7; i++) tm[i] = al[i] & fmask(i);
        if ($urandom % 2) begin
          int f;
          f = int'($urandom % 7);
          tm[f] = (al[f] + 16'd1) & fmask(f);
        end
      end else begin
        for (int i = 0; i < 7; i++) tm[i] = 16'($urandom) & fmask(i);
      end
      em = exp_match(al, tm, msk);
      load_alarm(al);
      wr(6'h08, {9'($urandom), msk});
      pulse_commit();
      wr(6'h04, (16'($urandom) & 16'hfff2) | 16'h0001 | (os ? 16'h0004 : 16'h0000));
      rd(6'h08, d); chk("R11 mask random", d, {9'h0, msk});
      tick_at(tm); chk("R4 random irq", 16'(irq_o), 16'(em));
      rd(6'h04, d); chk("R7 random enable", d, {13'h0, os, 1'b0, !(os && em)});
      rd(6'h02, d); chk("R4 random status", d, 16'(em));
      chk("R9 random irq cleared", 16'(irq_o), 16'h0);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule